// File: doc/BRIEF.md
# Instruction Count Trigger

This block is a countdown debug trigger for a processor core. Software loads a control word that holds a 14-bit remaining count and a set of per-privilege enable bits. Each retired instruction, reported by a one-cycle strobe, lowers the count by one, but only when the privilege level and virtualization state of that instruction are enabled in the control word. When the count steps from one to zero, the block asks the core for a breakpoint exception. The core then takes the exception at the next instruction boundary.

Reading the control word always shows the live remaining count, so a debugger can see how far the countdown has progressed. A count of zero parks the trigger: retired instructions then do nothing. Status and action fields that are not supported always read as zero. Writes aimed at the trigger's address-compare register are accepted on the bus but have no effect, because this trigger type has no compare value.

Top module: `itc_trigger`

## Requirements
- R1: After reset, the control word reads 0x3000_0000 (the type field is 3 and every other bit is zero), and the breakpoint request is low.
- R2: The control word layout is as follows. The remaining count sits at bits 23:10. The enables sit at bit 6 (U), bit 7 (S), bit 9 (M), bit 25 (virtual U) and bit 26 (virtual S). The type field at bits 31:28 always reads 3, whatever value is written. All other bits read as zero, including the action bits 5:0, pending bit 8, hit bit 24 and bit 27.
- R3: With virtualization off, a retired instruction at privilege p (U=0, S=1, M=3) decrements a non-zero count when control bit 6+p is set.
- R4: With virtualization on, a retired instruction at privilege U or S decrements a non-zero count when control bit 25+p is set. A retired instruction at privilege M never counts while virtualization is on.
- R5: A retired instruction in a mode whose enable bit is clear leaves the count unchanged. Privilege encoding 2 never counts.
- R6: A count of zero is idle: retired instructions neither change it nor raise a breakpoint request.
- R7: The breakpoint request is high for exactly one cycle. That cycle is the first cycle in which the control word reads a count of zero after an enabled retire stepped the count from 1.
- R8: A control write loads the new fields at the next clock edge and takes precedence over a retire in the same cycle. In that case there is no decrement and no breakpoint request.
- R9: A write aimed at the address register (select = 1) changes nothing that can be read back. A retire in the same cycle still counts normally.
- R10: The control word read port shows the remaining count after every decrement, in the same cycle the count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retire_i | input | 1 | One instruction retired this cycle |
| priv_i | input | 2 | Privilege level of the retiring instruction: 0 U, 1 S, 3 M |
| virt_i | input | 1 | Retiring instruction runs in a virtualized mode |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 1 | Write target: 0 control word, 1 address register |
| csr_wdata_i | input | XLEN | Write data |
| ctrl_rdata_o | output | XLEN | Control word with the live remaining count |
| brk_o | output | 1 | Single-cycle breakpoint exception request |

## Verification
The assertions assume that priv_i and virt_i are only meaningful when retire_i is high, and that a register write and a retire in the same cycle are legal and must be resolved by the block. The stimulus drives every input on the falling clock edge and holds it for one full cycle. Each mode and privilege combination is applied with retire both high and low. Write-plus-retire collisions are applied on purpose, including one on the last count.

// File: rtl/itc_pkg.sv
// Package: shared encodings and field positions of the instruction count trigger.
// Assumes a control word of at least 32 bits; positions are fixed by the layout.
package itc_pkg;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [3:0] TYPE_ICOUNT = 4'd3;

    localparam int POS_U   = 6;
    localparam int POS_S   = 7;
    localparam int POS_M   = 9;
    localparam int POS_VU  = 25;
    localparam int POS_VS  = 26;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_ADDR = 1'b1;

    // Per-mode enable bits held by the trigger
    typedef struct packed {
        logic vs;
        logic vu;
        logic m;
        logic s;
        logic u;
    } mode_en_t;

endpackage

// File: rtl/itc_mode_gate.sv
// Module: itc_mode_gate
// Decides whether an instruction retired at the given privilege level and
// virtualization state is enabled for counting. Purely combinational.
// Assumes priv/virt describe the retiring instruction; encoding 2 is reserved.
module itc_mode_gate
    import itc_pkg::*;
(
    input  mode_en_t   mode_en_i,
    input  logic [1:0] priv_i,
    input  logic       virt_i,
    output logic       count_en_o
);

    // Select the enable bit belonging to the current mode
    always_comb begin
        count_en_o = 1'b0;
        if (virt_i) begin
            case (priv_i)
                PRIV_U:  count_en_o = mode_en_i.vu;
                PRIV_S:  count_en_o = mode_en_i.vs;
                default: count_en_o = 1'b0;
            endcase
        end else begin
            case (priv_i)
                PRIV_U:  count_en_o = mode_en_i.u;
                PRIV_S:  count_en_o = mode_en_i.s;
                PRIV_M:  count_en_o = mode_en_i.m;
                default: count_en_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/itc_countdown.sv
// Module: itc_countdown
// Holds the remaining count. A load replaces it; otherwise an enabled step
// decrements a non-zero count, and the step from 1 to 0 registers a
// one-cycle fire pulse that appears together with the zero count.
// Assumes load and step may be high together; load wins.
module itc_countdown #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fire_o
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic live;
    assign live = (cnt_o != ZERO);

    // Count register and fire pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o  <= ZERO;
            fire_o <= 1'b0;
        end else begin
            fire_o <= 1'b0;
            if (load_i) begin
                cnt_o <= load_val_i;
            end else if (step_i && live) begin
                cnt_o  <= cnt_o - ONE;
                fire_o <= (cnt_o == ONE);
            end
        end
    end

    // R6: zero count without a load stays zero and never fires
    a_r6_idle_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == ZERO && !load_i) |=> (cnt_o == ZERO && !fire_o));

    // R3: an enabled step lowers a live count by one
    a_r3_step_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_i && live) |=> (cnt_o == $past(cnt_o) - ONE));

    // R5: without step or load the count holds
    a_r5_hold_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(cnt_o));

    // R7: a fire pulse only follows the last decrement
    a_r7_fire_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> (cnt_o == ZERO && $past(cnt_o) == ONE && !$past(load_i)));

    // R7: pulse lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    // R8: a load wins over a step and suppresses firing
    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == $past(load_val_i) && !fire_o));

endmodule

// File: rtl/itc_trigger.sv
// Module: itc_trigger (top)
// Instruction count trigger: stores the mode enables, gates the retire strobe
// by the current mode, counts down and requests a breakpoint at zero. The
// read port assembles the control word with the live count.
// Assumes XLEN >= 32; writes to the address register are accepted and dropped.
module itc_trigger
    import itc_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CNT_LSB = 10,
    parameter int CNT_W   = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            retire_i,
    input  logic [1:0]      priv_i,
    input  logic            virt_i,
    input  logic            csr_we_i,
    input  logic            csr_sel_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    output logic [XLEN-1:0] ctrl_rdata_o,
    output logic            brk_o
);

    localparam int TYPE_LSB = XLEN - 4;

    mode_en_t         mode_q;
    mode_en_t         mode_d;
    logic             load;
    logic             count_en;
    logic             step;
    logic [CNT_W-1:0] cnt;

    assign load = csr_we_i && (csr_sel_i == SEL_CTRL);
    assign step = retire_i && count_en;

    // Extract the enable bits from a control write
    always_comb begin
        mode_d.u  = csr_wdata_i[POS_U];
        mode_d.s  = csr_wdata_i[POS_S];
        mode_d.m  = csr_wdata_i[POS_M];
        mode_d.vu = csr_wdata_i[POS_VU];
        mode_d.vs = csr_wdata_i[POS_VS];
    end

    // Mode enable register, written only by a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (load) begin
            mode_q <= mode_d;
        end
    end

    itc_mode_gate u_gate (
        .mode_en_i  (mode_q),
        .priv_i     (priv_i),
        .virt_i     (virt_i),
        .count_en_o (count_en)
    );

    itc_countdown #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (csr_wdata_i[CNT_LSB +: CNT_W]),
        .step_i     (step),
        .cnt_o      (cnt),
        .fire_o     (brk_o)
    );

    // Assemble the readable control word; unsupported fields stay zero
    always_comb begin
        ctrl_rdata_o                        = '0;
        ctrl_rdata_o[TYPE_LSB +: 4]         = TYPE_ICOUNT;
        ctrl_rdata_o[CNT_LSB +: CNT_W]      = cnt;
        ctrl_rdata_o[POS_U]                 = mode_q.u;
        ctrl_rdata_o[POS_S]                 = mode_q.s;
        ctrl_rdata_o[POS_M]                 = mode_q.m;
        ctrl_rdata_o[POS_VU]                = mode_q.vu;
        ctrl_rdata_o[POS_VS]                = mode_q.vs;
    end

    // R4: machine mode under virtualization never moves the count
    a_r4_virt_m_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && virt_i && priv_i == PRIV_M) |=> $stable(ctrl_rdata_o));

    // R5: reserved privilege encoding never moves the count
    a_r5_reserved_priv_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && priv_i == 2'd2) |=> $stable(ctrl_rdata_o));

    // R9: address register writes without retire leave the control word alone
    a_r9_addr_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && csr_sel_i == SEL_ADDR && !retire_i) |=> $stable(ctrl_rdata_o));

    // R2: unsupported fields read zero, type reads constant
    a_r2_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ctrl_rdata_o[5:0] == '0 && !ctrl_rdata_o[8] && !ctrl_rdata_o[24]
                  && !ctrl_rdata_o[27] && ctrl_rdata_o[TYPE_LSB +: 4] == TYPE_ICOUNT));

    // R7: breakpoint request always coincides with a zero count on the read port
    a_r7_brk_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |-> (ctrl_rdata_o[CNT_LSB +: CNT_W] == '0));

endmodule

// File: tb/itc_trigger_bench.sv
`timescale 1ns/1ps
module itc_trigger_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire = 1'b0;
    logic [1:0]  priv = 2'd0;
    logic        virt = 1'b0;
    logic        we = 1'b0;
    logic        sel = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        brk;

    always #5 clk = ~clk;

    itc_trigger u_itc_trigger (
        .clk          (clk),
        .rst_n        (rst_n),
        .retire_i     (retire),
        .priv_i       (priv),
        .virt_i       (virt),
        .csr_we_i     (we),
        .csr_sel_i    (sel),
        .csr_wdata_i  (wdata),
        .ctrl_rdata_o (rdata),
        .brk_o        (brk)
    );

    typedef struct {
        logic [31:0] ctl;
        logic        brk;
        string       tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_fail = 0;

    // Reference state built from the requirements
    logic [13:0] m_cnt = '0;
    logic m_u = 0, m_s = 0, m_m = 0, m_vu = 0, m_vs = 0;

    function automatic logic [31:0] m_read();
        logic [31:0] r;
        r = 32'h3000_0000;
        r[23:10] = m_cnt;
        r[6] = m_u; r[7] = m_s; r[9] = m_m; r[25] = m_vu; r[26] = m_vs;
        return r;
    endfunction

    function automatic logic m_en(input logic [1:0] p, input logic v);
        if (v) return (p == 2'd0) ? m_vu : (p == 2'd1) ? m_vs : 1'b0;
        case (p)
            2'd0: return m_u;
            2'd1: return m_s;
            2'd3: return m_m;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] mk(input int c, input logic u, input logic s,
                                       input logic m, input logic vu, input logic vs);
        logic [31:0] w;
        w = '0;
        w[23:10] = c[13:0];
        w[6] = u; w[7] = s; w[9] = m; w[25] = vu; w[26] = vs;
        return w;
    endfunction

    // Driver: apply one cycle of stimulus and push the expected result
    task automatic cyc(input logic r, input logic [1:0] p, input logic v,
                       input logic w, input logic s, input logic [31:0] d, input string tag);
        logic b;
        @(negedge clk);
        retire = r; priv = p; virt = v; we = w; sel = s; wdata = d;
        b = 1'b0;
        if (w && !s) begin
            m_cnt = d[23:10];
            m_u = d[6]; m_s = d[7]; m_m = d[9]; m_vu = d[25]; m_vs = d[26];
        end else if (r && m_en(p, v) && m_cnt != 0) begin
            b = (m_cnt == 14'd1);
            m_cnt = m_cnt - 14'd1;
        end
        q.push_back('{m_read(), b, tag});
    endtask

    task automatic wr(input logic [31:0] d, input string tag);
        cyc(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, d, tag);
    endtask

    task automatic ret(input logic [1:0] p, input logic v, input string tag);
        cyc(1'b1, p, v, 1'b0, 1'b0, 32'h0, tag);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v,
                         input string what);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp_v);
        end
    endtask

    // Monitor: compare outputs after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, rdata, e.ctl, "ctrl");
                check(e.tag, {31'b0, brk}, {31'b0, e.brk}, "brk");
            end
        end
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #3;
        check("R1", rdata, 32'h3000_0000, "reset ctrl");
        check("R1", {31'b0, brk}, 32'h0, "reset brk");
        @(negedge clk);
        rst_n = 1'b1;
        ret(2'd3, 1'b0, "R1");

        // R2: layout and constant fields
        wr(32'hFFFF_FFFF, "R2");
        wr(32'h0000_0000, "R2");

        // R3 R7 R10: user-mode countdown to zero
        wr(mk(3, 1, 0, 0, 0, 0), "R3");
        ret(2'd0, 1'b0, "R10");
        cyc(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 0, "R10");
        ret(2'd0, 1'b0, "R3");
        ret(2'd0, 1'b0, "R7");
        ret(2'd0, 1'b0, "R6");

        // R5: S enabled only
        wr(mk(5, 0, 1, 0, 0, 0), "R5");
        ret(2'd0, 1'b0, "R5");
        ret(2'd3, 1'b0, "R5");
        ret(2'd2, 1'b0, "R5");
        ret(2'd1, 1'b1, "R5");
        ret(2'd1, 1'b0, "R3");

        // R4: virtual supervisor and user
        wr(mk(4, 0, 0, 1, 1, 1), "R4");
        ret(2'd1, 1'b1, "R4");
        ret(2'd0, 1'b1, "R4");
        ret(2'd3, 1'b1, "R4");
        ret(2'd2, 1'b1, "R4");
        ret(2'd3, 1'b0, "R3");
        ret(2'd0, 1'b1, "R7");
        ret(2'd0, 1'b1, "R6");

        // R6: zero count with all enables
        wr(mk(0, 1, 1, 1, 1, 1), "R6");
        for (int i = 0; i < 4; i++) ret(2'(i), 1'b0, "R6");

        // R8: write collides with retire
        wr(mk(2, 1, 0, 0, 0, 0), "R8");
        cyc(1'b1, 2'd0, 1'b0, 1'b1, 1'b0, mk(7, 1, 0, 0, 0, 0), "R8");
        wr(mk(1, 1, 0, 0, 0, 0), "R8");
        cyc(1'b1, 2'd0, 1'b0, 1'b1, 1'b0, mk(4, 1, 0, 0, 0, 0), "R8");
        ret(2'd0, 1'b0, "R8");

        // R9: address register writes
        cyc(1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 32'hDEAD_BEEF, "R9");
        cyc(1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 32'h0000_0000, "R9");
        cyc(1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R9");

        // R2 R7: full 14-bit count in machine mode
        wr(mk(16383, 0, 0, 1, 0, 0), "R2");
        for (int i = 0; i < 16383; i++) ret(2'd3, 1'b0, "R7");
        ret(2'd3, 1'b0, "R6");

        @(negedge clk);
        retire = 1'b0; we = 1'b0;
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule